// File: doc/BRIEF.md
# Relocation and Protection Unit

This block sits between a processor's address path and main memory. Every word address that a user program issues is turned into an absolute memory address. The same access is also checked against a small set of control registers that the supervisor loads. Relocation merges a base value into the address with a bitwise OR; it does not add it. A program therefore only runs correctly at a base whose set bits do not overlap the addresses it uses.

Two address spaces are available. The program region is bounded by a span register. Inside it, an inclusive guarded sub-range is reserved for I/O transfers, and user accesses to it are refused. A secondary workspace window starts at a configurable absolute address. Its size is selectable, and four of its upper pages can be locked one by one.

A supervisor-mode input bypasses all checks. Any refused access raises a one-cycle violation pulse on the following clock edge, and the offending address and a cause code are captured with it.

Top module: `reloc_guard`

## Requirements
- R1: In region mode (`win_sel`=0, `sup_mode`=0), `abs_addr` equals `uaddr` bitwise-ORed with the base register.
- R2: In region mode, an access with `uaddr` greater than or equal to the span register is refused, with cause code 0.
- R3: In region mode, an access with guard-low ≤ `uaddr` ≤ guard-high (both ends inclusive, and only when `uaddr` is below the span) is refused with cause code 1. When guard-low exceeds guard-high, no address is guarded.
- R4: In window mode (`win_sel`=1), `abs_addr` equals the window start (workspace register bits [17:0]) ORed with the low 12 bits of `uaddr`.
- R5: The window size field (workspace register bits [19:18]) selects 64, 512 or 4096 words for codes 0, 1 and 2. An offset at or beyond the size is refused with cause code 2. Code 3 refuses every window access, also with cause code 2.
- R6: Workspace register bit 20+i locks window offsets 2048+512·i through 2559+512·i, for i = 0 to 3. A locked offset is refused with cause code 3.
- R7: When `sup_mode`=1, `permit` follows `acc_valid`, `abs_addr` equals `uaddr`, and no violation is raised.
- R8: `permit` is 0 whenever `acc_valid` is 0, and no violation follows such a cycle.
- R9: A valid access that is refused sets `viol` for exactly the next cycle. At that edge it also loads `viol_addr` with the user address and `viol_cause` with the cause. `viol_addr` and `viol_cause` keep their values at all other edges.
- R10: Register writes take effect at the next clock edge. The `wr_sel` codes are 0 base, 1 span, 2 guard-high, 3 guard-low and 4 workspace; codes 5 to 7 change nothing. Reset clears every register, so the span is 0 and every region access is refused.
- R11: In region mode the span check takes priority over the guard check, so an address that fails both reports cause code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 24 | Write data; region registers use bits [17:0] |
| acc_valid | input | 1 | Access strobe |
| sup_mode | input | 1 | Supervisor bypass |
| win_sel | input | 1 | 1 selects the workspace window, 0 the program region |
| uaddr | input | 18 | User word address or window offset |
| abs_addr | output | 18 | Absolute word address |
| permit | output | 1 | Access allowed this cycle |
| viol | output | 1 | Registered violation pulse |
| viol_addr | output | 18 | Captured offending user address |
| viol_cause | output | 2 | Captured cause: 0 span, 1 guard, 2 window range, 3 page lock |

## Verification
The assertions take it that the control registers are not rewritten in the same cycle as an access they are meant to govern. A write lands at the edge, so a permit computed in that cycle reflects the old values. The bench keeps register writes and access strobes in separate cycles. It draws guard bounds inside the span and window offsets a little past 4096 so that every cause code occurs. Directed cases sit on each boundary: span−1 and span, both guard ends, the last offset of each window size, and the first and last offset of every locked page.

// File: rtl/rpu_pkg.sv
// Package rpu_pkg
// Shared types and register select codes for the relocation and protection
// unit. Assumes cause codes are visible to software as 2-bit values.
package rpu_pkg;

    typedef enum logic [1:0] {
        CAUSE_SPAN   = 2'd0,
        CAUSE_GUARD  = 2'd1,
        CAUSE_WINDOW = 2'd2,
        CAUSE_PAGE   = 2'd3
    } cause_e;

    localparam logic [2:0] SEL_BASE     = 3'd0;
    localparam logic [2:0] SEL_SPAN     = 3'd1;
    localparam logic [2:0] SEL_GUARD_HI = 3'd2;
    localparam logic [2:0] SEL_GUARD_LO = 3'd3;
    localparam logic [2:0] SEL_WKSP     = 3'd4;

endpackage

// File: rtl/rpu_regs.sv
// Module rpu_regs
// Control register file: base, span, guard bounds and workspace control.
// Assumes one write per cycle; unknown selects are ignored. All registers
// clear on synchronous active-low reset.
module rpu_regs
    import rpu_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int NUM_LOCKS = 4,
    localparam int CTRL_W   = ADDR_W + 2 + NUM_LOCKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [CTRL_W-1:0]    wr_data,
    output logic [ADDR_W-1:0]    base_q,
    output logic [ADDR_W-1:0]    span_q,
    output logic [ADDR_W-1:0]    guard_hi_q,
    output logic [ADDR_W-1:0]    guard_lo_q,
    output logic [ADDR_W-1:0]    wk_start,
    output logic [1:0]           wk_size,
    output logic [NUM_LOCKS-1:0] wk_lock
);

    logic [CTRL_W-1:0] wksp_q;

    // Load the selected register on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            span_q     <= '0;
            guard_hi_q <= '0;
            guard_lo_q <= '0;
            wksp_q     <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_BASE:     base_q     <= wr_data[ADDR_W-1:0];
                SEL_SPAN:     span_q     <= wr_data[ADDR_W-1:0];
                SEL_GUARD_HI: guard_hi_q <= wr_data[ADDR_W-1:0];
                SEL_GUARD_LO: guard_lo_q <= wr_data[ADDR_W-1:0];
                SEL_WKSP:     wksp_q     <= wr_data;
                default:      ;
            endcase
        end
    end

    // Split the workspace register into its fields
    assign wk_start = wksp_q[ADDR_W-1:0];
    assign wk_size  = wksp_q[ADDR_W+1:ADDR_W];
    assign wk_lock  = wksp_q[ADDR_W+2 +: NUM_LOCKS];

    // R10: a span write is visible after the edge
    p_span_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SPAN) |=> (span_q == $past(wr_data[ADDR_W-1:0])));

    // R10: unused selects leave the workspace untouched
    p_bad_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_WKSP) |=> $stable(wksp_q));

endmodule

// File: rtl/rpu_region.sv
// Module rpu_region
// Program region check and OR relocation. Assumes the span and guard
// registers are stable during the access. The span check has priority.
module rpu_region
    import rpu_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] uaddr,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [ADDR_W-1:0] span_q,
    input  logic [ADDR_W-1:0] guard_hi_q,
    input  logic [ADDR_W-1:0] guard_lo_q,
    output logic [ADDR_W-1:0] r_abs,
    output logic              r_ok,
    output cause_e            r_cause
);

    logic over_span;
    logic in_guard;

    // Relocate by merging the base bits
    assign r_abs = uaddr | base_q;

    // Classify the address against the span and the guarded sub-range
    always_comb begin
        over_span = (uaddr >= span_q);
        in_guard  = (uaddr >= guard_lo_q) && (uaddr <= guard_hi_q);
    end

    // Pick outcome and cause with the span check first
    always_comb begin
        r_ok    = 1'b1;
        r_cause = CAUSE_SPAN;
        if (over_span) begin
            r_ok    = 1'b0;
            r_cause = CAUSE_SPAN;
        end else if (in_guard) begin
            r_ok    = 1'b0;
            r_cause = CAUSE_GUARD;
        end
    end

endmodule

// File: rtl/rpu_window.sv
// Module rpu_window
// Workspace window check and OR relocation. Window size is
// 2^(WIN_MIN_LOG + WIN_STEP_LOG*code) for codes 0..2; code 3 disables it.
// The upper half of the largest window is split into NUM_LOCKS pages that
// can be locked one by one. Assumes NUM_LOCKS is a power of two.
module rpu_window
    import rpu_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int WIN_MIN_LOG  = 6,
    parameter int WIN_STEP_LOG = 3,
    parameter int NUM_LOCKS    = 4
) (
    input  logic [ADDR_W-1:0]    uaddr,
    input  logic [ADDR_W-1:0]    wk_start,
    input  logic [1:0]           wk_size,
    input  logic [NUM_LOCKS-1:0] wk_lock,
    output logic [ADDR_W-1:0]    w_abs,
    output logic                 w_ok,
    output cause_e               w_cause
);

    localparam int WIN_OFF_W  = WIN_MIN_LOG + 2 * WIN_STEP_LOG;
    localparam int LOCK_IDX_W = $clog2(NUM_LOCKS);
    localparam int PAGE_LOG   = WIN_OFF_W - 1 - LOCK_IDX_W;

    logic [ADDR_W:0]       win_limit;
    logic                  win_off;
    logic                  in_range;
    logic [NUM_LOCKS-1:0]  page_hit;
    logic                  locked;

    // Relocate the window offset onto the window start
    assign w_abs = wk_start | {{(ADDR_W-WIN_OFF_W){1'b0}}, uaddr[WIN_OFF_W-1:0]};

    // Decode the size field into an exclusive word limit
    always_comb begin
        win_off   = 1'b0;
        win_limit = '0;
        case (wk_size)
            2'd0:    win_limit = (ADDR_W+1)'(1) << WIN_MIN_LOG;
            2'd1:    win_limit = (ADDR_W+1)'(1) << (WIN_MIN_LOG + WIN_STEP_LOG);
            2'd2:    win_limit = (ADDR_W+1)'(1) << WIN_OFF_W;
            default: win_off   = 1'b1;
        endcase
    end

    assign in_range = ({1'b0, uaddr} < win_limit);

    // One comparator per lockable page in the upper half
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_page
        assign page_hit[i] = wk_lock[i] && uaddr[WIN_OFF_W-1]
                           && (uaddr[PAGE_LOG +: LOCK_IDX_W] == LOCK_IDX_W'(i));
    end

    assign locked = |page_hit;

    // Choose outcome: disabled or out of range first, then page lock
    always_comb begin
        w_ok    = 1'b1;
        w_cause = CAUSE_WINDOW;
        if (win_off || !in_range) begin
            w_ok    = 1'b0;
            w_cause = CAUSE_WINDOW;
        end else if (locked) begin
            w_ok    = 1'b0;
            w_cause = CAUSE_PAGE;
        end
    end

endmodule

// File: rtl/rpu_flag.sv
// Module rpu_flag
// Registers the violation pulse and captures address and cause of a
// refused access. Assumes capture is already qualified by the strobe.
module rpu_flag
    import rpu_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] uaddr,
    input  cause_e            cause,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [1:0]        viol_cause
);

    // Pulse the flag one cycle after a refused access
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= capture;
    end

    // Hold the last offending address and cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_addr  <= '0;
            viol_cause <= '0;
        end else if (capture) begin
            viol_addr  <= uaddr;
            viol_cause <= cause;
        end
    end

endmodule

// File: rtl/reloc_guard.sv
// Module reloc_guard
// Top of the relocation and protection unit. Selects between program
// region and workspace window, applies the supervisor bypass and drives
// the registered violation report. Assumes register writes and governed
// accesses fall in different cycles.
module reloc_guard
    import rpu_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int WIN_MIN_LOG  = 6,
    parameter int WIN_STEP_LOG = 3,
    parameter int NUM_LOCKS    = 4,
    localparam int CTRL_W      = ADDR_W + 2 + NUM_LOCKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              sup_mode,
    input  logic              win_sel,
    input  logic [ADDR_W-1:0] uaddr,
    output logic [ADDR_W-1:0] abs_addr,
    output logic              permit,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [1:0]        viol_cause
);

    logic [ADDR_W-1:0]    base_q, span_q, guard_hi_q, guard_lo_q, wk_start;
    logic [1:0]           wk_size;
    logic [NUM_LOCKS-1:0] wk_lock;
    logic [ADDR_W-1:0]    r_abs, w_abs;
    logic                 r_ok, w_ok, sel_ok, refuse;
    cause_e               r_cause, w_cause, sel_cause;

    rpu_regs #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .base_q(base_q), .span_q(span_q),
        .guard_hi_q(guard_hi_q), .guard_lo_q(guard_lo_q),
        .wk_start(wk_start), .wk_size(wk_size), .wk_lock(wk_lock)
    );

    rpu_region #(.ADDR_W(ADDR_W)) u_region (
        .uaddr(uaddr), .base_q(base_q), .span_q(span_q),
        .guard_hi_q(guard_hi_q), .guard_lo_q(guard_lo_q),
        .r_abs(r_abs), .r_ok(r_ok), .r_cause(r_cause)
    );

    rpu_window #(.ADDR_W(ADDR_W), .WIN_MIN_LOG(WIN_MIN_LOG),
                 .WIN_STEP_LOG(WIN_STEP_LOG), .NUM_LOCKS(NUM_LOCKS)) u_window (
        .uaddr(uaddr), .wk_start(wk_start), .wk_size(wk_size),
        .wk_lock(wk_lock), .w_abs(w_abs), .w_ok(w_ok), .w_cause(w_cause)
    );

    // Steer the selected space's result, with the supervisor bypass on top
    always_comb begin
        sel_ok    = win_sel ? w_ok    : r_ok;
        sel_cause = win_sel ? w_cause : r_cause;
        if (sup_mode) abs_addr = uaddr;
        else          abs_addr = win_sel ? w_abs : r_abs;
        permit = acc_valid && (sup_mode || sel_ok);
        refuse = acc_valid && !sup_mode && !sel_ok;
    end

    rpu_flag #(.ADDR_W(ADDR_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .capture(refuse), .uaddr(uaddr),
        .cause(sel_cause), .viol(viol), .viol_addr(viol_addr),
        .viol_cause(viol_cause)
    );

    // R2: addresses at or past the span never get through in region mode
    p_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sup_mode && !win_sel && uaddr >= span_q) |-> !permit);

    // R3: guarded addresses never get through in region mode
    p_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sup_mode && !win_sel && uaddr >= guard_lo_q
         && uaddr <= guard_hi_q) |-> !permit);

    // R5: a disabled window admits nothing
    p_window_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sup_mode && win_sel && wk_size == 2'd3) |-> !permit);

    // R7: supervisor accesses pass unmodified
    p_super_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sup_mode) |-> (permit && abs_addr == uaddr));

    // R8: no strobe, no permit
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !permit);

    // R9: a refused access raises the flag and captures its address
    p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !permit) |=> (viol && viol_addr == $past(uaddr)));

    // R9: otherwise the flag stays low and the capture holds
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !permit) |=> (!viol && $stable(viol_addr)
                                     && $stable(viol_cause)));

endmodule

// File: tb/tb_reloc_guard.sv
module tb_reloc_guard;

    localparam int AW = 18;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [CW-1:0] wr_data = '0;
    logic          acc_valid = 1'b0;
    logic          sup_mode = 1'b0;
    logic          win_sel = 1'b0;
    logic [AW-1:0] uaddr = '0;
    logic [AW-1:0] abs_addr;
    logic          permit;
    logic          viol;
    logic [AW-1:0] viol_addr;
    logic [1:0]    viol_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench-side copies of what was written
    logic [AW-1:0] m_base = '0, m_span = '0, m_hi = '0, m_lo = '0;
    logic [CW-1:0] m_wk = '0;

    reloc_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .acc_valid(acc_valid), .sup_mode(sup_mode),
        .win_sel(win_sel), .uaddr(uaddr), .abs_addr(abs_addr),
        .permit(permit), .viol(viol), .viol_addr(viol_addr),
        .viol_cause(viol_cause)
    );

    always #5 clk = ~clk;

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // expected {ok, cause, abs} from the requirements
    function automatic logic [20:0] model(input logic sup, input logic win,
                                          input logic [AW-1:0] a);
        logic [1:0] code;
        int words;
        if (sup) return {1'b1, 2'd0, a};
        if (!win) begin
            if (a >= m_span) return {1'b0, 2'd0, a | m_base};
            if (a >= m_lo && a <= m_hi) return {1'b0, 2'd1, a | m_base};
            return {1'b1, 2'd0, a | m_base};
        end
        code = m_wk[19:18];
        if (code == 2'd3) return {1'b0, 2'd2, 18'd0};
        words = 64 << (3 * code);
        if (int'(a) >= words) return {1'b0, 2'd2, 18'd0};
        if (a[11] && m_wk[20 + a[10:9]]) return {1'b0, 2'd3, 18'd0};
        return {1'b1, 2'd2, m_wk[17:0] | {6'd0, a[11:0]}};
    endfunction

    // write one control register; called at a falling edge
    task automatic wr(input logic [2:0] sel, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        case (sel)
            3'd0: m_base = d[17:0];
            3'd1: m_span = d[17:0];
            3'd2: m_hi   = d[17:0];
            3'd3: m_lo   = d[17:0];
            3'd4: m_wk   = d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one access: check permit/abs now, flag after the next edge
    task automatic acc(input string req, input logic sup, input logic win,
                       input logic [AW-1:0] a);
        logic [20:0] e;
        e = model(sup, win, a);
        acc_valid = 1'b1; sup_mode = sup; win_sel = win; uaddr = a;
        #1;
        chk(req, {31'd0, permit}, {31'd0, e[20]});
        if (e[20]) chk(req, {14'd0, abs_addr}, {14'd0, e[17:0]});
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R9", {31'd0, viol}, {31'd0, ~e[20]});
        if (!e[20]) begin
            chk("R9", {14'd0, viol_addr}, {14'd0, a});
            chk(req, {30'd0, viol_cause}, {30'd0, e[19:18]});
        end
    endtask

    initial begin
        logic [AW-1:0] held;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        chk("R10", {31'd0, viol}, 32'd0);
        chk("R8", {31'd0, permit}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset leaves span 0, so any region access is refused
        acc("R10", 1'b0, 1'b0, 18'd5);

        // R8: idle strobe gives no permit and no flag
        uaddr = 18'd1; win_sel = 1'b0; sup_mode = 1'b1; #1;
        chk("R8", {31'd0, permit}, 32'd0);
        @(negedge clk); chk("R8", {31'd0, viol}, 32'd0);

        // R1, R2, R3, R11 directed boundaries
        wr(3'd0, 24'h0_4000);
        wr(3'd1, 24'd1000);
        wr(3'd3, 24'd100);
        wr(3'd2, 24'd200);
        acc("R1", 1'b0, 1'b0, 18'd0);
        acc("R1", 1'b0, 1'b0, 18'd99);
        acc("R3", 1'b0, 1'b0, 18'd100);
        acc("R3", 1'b0, 1'b0, 18'd200);
        acc("R3", 1'b0, 1'b0, 18'd201);
        acc("R2", 1'b0, 1'b0, 18'd999);
        acc("R2", 1'b0, 1'b0, 18'd1000);
        // R11: guard straddling the span end still reports span cause
        wr(3'd2, 24'd1500);
        acc("R11", 1'b0, 1'b0, 18'd1200);
        // R3: inverted guard guards nothing
        wr(3'd3, 24'd600); wr(3'd2, 24'd500);
        acc("R3", 1'b0, 1'b0, 18'd550);

        // R10: writes to unused selects change nothing
        wr(3'd5, 24'h0);
        wr(3'd7, 24'h0);
        acc("R10", 1'b0, 1'b0, 18'd999);
        acc("R10", 1'b0, 1'b0, 18'd1000);

        // R7: supervisor bypass on a span violation
        acc("R7", 1'b1, 1'b0, 18'd3_0000);

        // R4, R5 window sizes and R6 page locks
        wr(3'd4, {4'b0000, 2'd0, 18'h1_0000});
        acc("R4", 1'b0, 1'b1, 18'd63);
        acc("R5", 1'b0, 1'b1, 18'd64);
        wr(3'd4, {4'b0000, 2'd1, 18'h1_0000});
        acc("R5", 1'b0, 1'b1, 18'd511);
        acc("R5", 1'b0, 1'b1, 18'd512);
        wr(3'd4, {4'b1001, 2'd2, 18'h2_0000});
        acc("R6", 1'b0, 1'b1, 18'd2047);
        acc("R6", 1'b0, 1'b1, 18'd2048);
        acc("R6", 1'b0, 1'b1, 18'd2559);
        acc("R6", 1'b0, 1'b1, 18'd2560);
        acc("R6", 1'b0, 1'b1, 18'd3583);
        acc("R6", 1'b0, 1'b1, 18'd3584);
        acc("R6", 1'b0, 1'b1, 18'd4095);
        acc("R5", 1'b0, 1'b1, 18'd4096);
        wr(3'd4, {4'b0000, 2'd3, 18'h2_0000});
        acc("R5", 1'b0, 1'b1, 18'd0);

        // R9: capture holds across a permitted access
        held = viol_addr;
        acc("R9", 1'b0, 1'b0, 18'd10);
        chk("R9", {14'd0, viol_addr}, {14'd0, held});

        // random mix
        for (int round = 0; round < 60; round++) begin
            int sp;
            sp = $urandom_range(16, 200000);
            wr(3'd0, CW'($urandom_range(0, 262143)));
            wr(3'd1, CW'(sp));
            wr(3'd3, CW'($urandom_range(0, sp)));
            wr(3'd2, CW'($urandom_range(0, sp)));
            wr(3'd4, CW'($urandom));
            for (int k = 0; k < 10; k++) begin
                logic s, w;
                s = ($urandom_range(0, 7) == 0);
                w = $urandom_range(0, 1) == 1;
                if (s)      acc("R7", 1'b1, w, AW'($urandom));
                else if (w) acc("R4", 1'b0, 1'b1, AW'($urandom_range(0, 4200)));
                else        acc("R1", 1'b0, 1'b0, AW'($urandom_range(0, sp + 16)));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule